// File: doc/BRIEF.md
# Sample Output Formatter with Test Patterns

This block sits between a converter core and the parallel output pins. It takes unsigned samples (offset binary) together with a valid strobe and an over-range flag. It drives a registered output word, a registered over-range bit, a data-valid bit and a capture-edge indication. The output word can be sent as straight offset binary or as two's complement. Live samples can be replaced by one of three test patterns: all zeros, all ones, or a toggling pattern in which each bit switches on its own schedule.

Test patterns are built in offset binary and then go through the same format conversion as live data. Two's complement is formed by inverting the most significant bit only. An active-high output enable forces the word and the over-range bit to zero. A polarity bit tells the downstream capture register whether the word is valid on the rising edge (0) or on the falling edge (1). Every output has one register stage of latency.

Top module: `adc_out_formatter`

## Requirements
- R1: While reset is high and in the first cycle after it, out_data, out_ovr, out_valid and out_pol are all 0.
- R2: out_valid equals in_valid one cycle later. With test_mode = 00, out_en = 1 and fmt_twos = 0, a sample taken with in_valid = 1 appears unchanged on out_data one cycle later.
- R3: With fmt_twos = 1, the output word is the offset-binary word with only bit W-1 inverted, so live 0x000 becomes 0x800 and 0xFFF becomes 0x7FF.
- R4: With test_mode = 01, the offset-binary word is all zeros. It is output as 0x000 in straight binary and as 0x800 in two's complement.
- R5: With test_mode = 10, the offset-binary word is all ones. It is output as 0xFFF in straight binary and as 0x7FF in two's complement.
- R6: With test_mode = 11, number the valid samples k = 0, 1, 2, … from the cycle the mode is entered. In the offset-binary word for sample k, every even-indexed bit equals bit 0 of k and every odd-indexed bit equals bit 1 of k. Cycles without a valid sample do not advance k. Any cycle in another mode restarts k at 0.
- R7: out_ovr carries in_ovr of a valid sample in mode 00. It is 0 after a valid sample in any test mode.
- R8: When out_en is 0, out_data and out_ovr are 0 in the next cycle, whatever in_valid is.
- R9: out_pol equals pol_fall one cycle later (0 means rising-edge capture, 1 means falling-edge capture).
- R10: With out_en = 1 and in_valid = 0, out_data and out_ovr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new raw sample |
| in_data | input | W | Raw sample, offset binary |
| in_ovr | input | 1 | Over-range flag of the raw sample |
| test_mode | input | 2 | 00 live, 01 zeros, 10 ones, 11 toggle |
| fmt_twos | input | 1 | 1 selects two's complement output |
| pol_fall | input | 1 | 1 selects falling-edge capture |
| out_en | input | 1 | Output enable, active high |
| out_data | output | W | Formatted output word |
| out_ovr | output | 1 | Registered over-range bit |
| out_valid | output | 1 | Registered data-valid bit |
| out_pol | output | 1 | Capture-edge indication |

## Verification
The bench builds the formatter with the default 12-bit word. At that width the odd bits include the MSB, so two's-complement conversion visibly interacts with the toggle schedule. The 0x555/0xAAA split shows that even and odd bits switch at different rates. Toggle sequences with gaps, and with a re-entry into the mode, exercise the restart of the sample count. The enable and hold cases are interleaved with live data, so a value held stale, or a word left ungated, shows up in the following cycle.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    TM_LIVE   = 2'b00,
    TM_ZERO   = 2'b01,
    TM_ONES   = 2'b10,
    TM_TOGGLE = 2'b11
  } tmode_e;
endpackage

// File: rtl/adc_fmt_patgen.sv
module adc_fmt_patgen
  import adc_fmt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         advance,
  input  logic [W-1:0] live_data,
  output logic [W-1:0] word
);
  logic [W-1:0] tog_q;
  logic         phase_q;
  logic         step;

  assign step = advance && (mode == TM_TOGGLE);

  always_ff @(posedge clk) begin
    if (rst || mode != TM_TOGGLE) phase_q <= 1'b0;
    else if (step)                phase_q <= ~phase_q;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i % 2 == 0) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst || mode != TM_TOGGLE) tog_q[i] <= 1'b0;
        else if (step)                tog_q[i] <= ~tog_q[i];
      end
    end else begin : g_slow
      always_ff @(posedge clk) begin
        if (rst || mode != TM_TOGGLE)  tog_q[i] <= 1'b0;
        else if (step && phase_q)      tog_q[i] <= ~tog_q[i];
      end
    end
  end

  always_comb begin
    unique case (mode)
      TM_LIVE:   word = live_data;
      TM_ZERO:   word = '0;
      TM_ONES:   word = '1;
      default:   word = tog_q;
    endcase
  end

  // R6: outside toggle mode the toggle state is cleared on the next edge
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (mode != TM_TOGGLE) |=> (tog_q == '0 && !phase_q));
endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv #(
  parameter int W = 12
) (
  input  logic         twos,
  input  logic [W-1:0] ob_word,
  output logic [W-1:0] fmt_word
);
  localparam int MSB = W - 1;

  always_comb begin
    fmt_word      = ob_word;
    fmt_word[MSB] = ob_word[MSB] ^ twos;
  end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adc_fmt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_ovr,
  input  logic [1:0]   test_mode,
  input  logic         fmt_twos,
  input  logic         pol_fall,
  input  logic         out_en,
  output logic [W-1:0] out_data,
  output logic         out_ovr,
  output logic         out_valid,
  output logic         out_pol
);
  tmode_e       mode;
  logic [W-1:0] ob_word;
  logic [W-1:0] fmt_word;

  assign mode = tmode_e'(test_mode);

  adc_fmt_patgen #(.W(W)) patgen_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .advance   (in_valid),
    .live_data (in_data),
    .word      (ob_word)
  );

  adc_fmt_conv #(.W(W)) conv_i (
    .twos     (fmt_twos),
    .ob_word  (ob_word),
    .fmt_word (fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_ovr   <= 1'b0;
      out_valid <= 1'b0;
      out_pol   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_pol   <= pol_fall;
      if (!out_en) begin
        out_data <= '0;
        out_ovr  <= 1'b0;
      end else if (in_valid) begin
        out_data <= fmt_word;
        out_ovr  <= in_ovr && (mode == TM_LIVE);
      end
    end
  end

  // R2: valid tracks the strobe with one cycle of latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R8: a disabled output reads as zero
  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (out_data == '0 && !out_ovr));

  // R7: test patterns never flag over-range
  a_r7_test_no_ovr: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_en && test_mode != 2'b00) |=> !out_ovr);

  // R10: without a new sample the enabled output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_en) |=> ($stable(out_data) && $stable(out_ovr)));

  // R9: polarity indication is a delayed copy of the select
  a_r9_pol: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_pol == $past(pol_fall)));

  // R4: zero pattern in straight binary
  a_r4_zero_pattern: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_en && test_mode == 2'b01 && !fmt_twos) |=> (out_data == '0));

  // R5: ones pattern in straight binary
  a_r5_ones_pattern: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_en && test_mode == 2'b10 && !fmt_twos) |=> (out_data == '1));
endmodule

// File: tb/adc_out_formatter_tb.sv
module adc_out_formatter_tb_top;
  localparam int W = 12;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ovr;
  logic [1:0]   test_mode;
  logic         fmt_twos;
  logic         pol_fall;
  logic         out_en;
  logic [W-1:0] out_data;
  logic         out_ovr;
  logic         out_valid;
  logic         out_pol;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_formatter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .test_mode(test_mode), .fmt_twos(fmt_twos),
    .pol_fall(pol_fall), .out_en(out_en), .out_data(out_data),
    .out_ovr(out_ovr), .out_valid(out_valid), .out_pol(out_pol)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] q_data[$];
  logic         q_ovr[$];
  logic         q_valid[$];
  logic         q_pol[$];
  string        q_tag[$];

  logic [W-1:0] m_data = '0;
  logic         m_ovr  = 1'b0;
  int           m_k    = 0;

  function automatic logic [W-1:0] tog_word(int k);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = (i % 2 == 0) ? k[0] : k[1];
    return w;
  endfunction

  task automatic drive(input logic v, input logic [W-1:0] d, input logic ovr,
                       input logic [1:0] mode, input logic twos, input logic pol,
                       input logic oe, input string tag);
    logic [W-1:0] ob;
    @(negedge clk);
    in_valid = v; in_data = d; in_ovr = ovr; test_mode = mode;
    fmt_twos = twos; pol_fall = pol; out_en = oe;
    case (mode)
      2'b00:   ob = d;
      2'b01:   ob = '0;
      2'b10:   ob = '1;
      default: ob = tog_word(m_k);
    endcase
    ob[W-1] = ob[W-1] ^ twos;
    if (mode != 2'b11) m_k = 0;
    else if (v)        m_k = m_k + 1;
    if (!oe) begin
      m_data = '0; m_ovr = 1'b0;
    end else if (v) begin
      m_data = ob; m_ovr = ovr && (mode == 2'b00);
    end
    q_data.push_back(m_data); q_ovr.push_back(m_ovr);
    q_valid.push_back(v); q_pol.push_back(pol); q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_data.size() > 0) begin
        logic [W-1:0] ed;
        logic eo, ev, ep;
        string t;
        ed = q_data.pop_front(); eo = q_ovr.pop_front();
        ev = q_valid.pop_front(); ep = q_pol.pop_front(); t = q_tag.pop_front();
        checks++;
        if (out_data !== ed || out_ovr !== eo || out_valid !== ev || out_pol !== ep) begin
          errors++;
          $display("FAIL %s: got data=%h ovr=%b valid=%b pol=%b, expected data=%h ovr=%b valid=%b pol=%b",
                   t, out_data, out_ovr, out_valid, out_pol, ed, eo, ev, ep);
        end
      end
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    rst = 1'b1; in_valid = 0; in_data = '0; in_ovr = 0; test_mode = 2'b00;
    fmt_twos = 0; pol_fall = 0; out_en = 1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if (out_data !== '0 || out_ovr !== 0 || out_valid !== 0 || out_pol !== 0) begin
      errors++;
      $display("FAIL R1: got data=%h ovr=%b valid=%b pol=%b, expected all zero",
               out_data, out_ovr, out_valid, out_pol);
    end
    @(negedge clk); rst = 1'b0;

    // R1 first cycle after reset with idle input
    drive(0, 12'h000, 0, 2'b00, 0, 0, 1, "R1");
    // R2 live straight binary
    drive(1, 12'h000, 0, 2'b00, 0, 0, 1, "R2");
    drive(1, 12'hFFF, 0, 2'b00, 0, 0, 1, "R2");
    drive(1, 12'hA5A, 0, 2'b00, 0, 0, 1, "R2");
    drive(1, 12'h800, 0, 2'b00, 0, 0, 1, "R2");
    // R10 hold with gaps
    drive(0, 12'h123, 1, 2'b00, 0, 0, 1, "R10");
    drive(0, 12'h456, 0, 2'b00, 0, 0, 1, "R10");
    // R3 two's complement
    drive(1, 12'h000, 0, 2'b00, 1, 0, 1, "R3");
    drive(1, 12'hFFF, 0, 2'b00, 1, 0, 1, "R3");
    drive(1, 12'h7FF, 0, 2'b00, 1, 0, 1, "R3");
    drive(1, 12'h3C5, 0, 2'b00, 1, 0, 1, "R3");
    // R7 over-range live and in test modes
    drive(1, 12'hFFF, 1, 2'b00, 0, 0, 1, "R7");
    drive(0, 12'h000, 0, 2'b00, 0, 0, 1, "R7");
    drive(1, 12'hFFF, 1, 2'b01, 0, 0, 1, "R7");
    drive(1, 12'hFFF, 1, 2'b00, 0, 0, 1, "R7");
    drive(1, 12'hFFF, 1, 2'b10, 0, 0, 1, "R7");
    // R4 / R5 fixed patterns in both formats
    drive(1, 12'h5A5, 0, 2'b01, 0, 0, 1, "R4");
    drive(1, 12'h5A5, 0, 2'b01, 1, 0, 1, "R4");
    drive(1, 12'h5A5, 0, 2'b10, 0, 0, 1, "R5");
    drive(1, 12'h5A5, 0, 2'b10, 1, 0, 1, "R5");
    // R6 toggle straight binary, with a gap
    drive(0, 12'h000, 0, 2'b00, 0, 0, 1, "R6");
    for (int s = 0; s < 5; s++) drive(1, 12'h0F0, 0, 2'b11, 0, 0, 1, "R6");
    drive(0, 12'h0F0, 0, 2'b11, 0, 0, 1, "R6");
    for (int s = 0; s < 3; s++) drive(1, 12'h0F0, 1, 2'b11, 0, 0, 1, "R6");
    // R6 restart and two's complement
    drive(1, 12'h111, 0, 2'b00, 0, 0, 1, "R6");
    for (int s = 0; s < 5; s++) drive(1, 12'h0F0, 0, 2'b11, 1, 0, 1, "R6");
    // R8 output enable low, with and without valid
    drive(1, 12'hABC, 1, 2'b00, 0, 0, 0, "R8");
    drive(0, 12'hABC, 1, 2'b00, 0, 0, 0, "R8");
    drive(0, 12'hABC, 1, 2'b00, 0, 0, 1, "R8");
    drive(1, 12'hABC, 1, 2'b00, 0, 0, 1, "R8");
    drive(1, 12'h321, 0, 2'b11, 0, 0, 0, "R8");
    // R9 polarity
    drive(1, 12'h0AA, 0, 2'b00, 0, 1, 1, "R9");
    drive(1, 12'h055, 0, 2'b00, 1, 1, 1, "R9");
    drive(0, 12'h055, 0, 2'b00, 1, 0, 1, "R9");
    drive(1, 12'h9E1, 0, 2'b00, 0, 1, 1, "R9");
    drive(0, 12'h000, 0, 2'b00, 0, 0, 1, "R2");

    while (q_data.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule